// File: doc/BRIEF.md
# Message bus register endpoint

This block answers register accesses that arrive over a narrow control bus between a link controller and its physical layer. Each request is sent one byte per clock on an 8-bit inbound bus: a header byte that holds the command and the top of a 12-bit address, then the low address byte, then a data byte if the request is a write. The block answers on an 8-bit outbound bus that is registered and reads as zero when it has nothing to send.

Writes come in two kinds. A staged write is held in a small ordered buffer and does not touch the register file. A committing write makes every staged write and the committing write itself take effect on the same clock edge, in arrival order. The block then returns one write acknowledge byte. A read returns a two-beat completion: a header byte followed by the register contents.

The hosted registers sit in four regions of the address space. In every register, the bits named by a pulse mask self-clear one clock after they are written. All other bits hold their value until the next write.

Top module: `mbus_endpoint`

## Requirements
- R1: While rst_n is low, and on its release, mbus_out is 0x00, every bit of reg_q is 0 and stage_ovf is 0.
- R2: A request is framed as follows. The header byte holds the command in bits [7:4] and address bits [11:8] in bits [3:0]. The next byte holds address bits [7:0]. A third byte holds the data, and only writes carry it. Request command codes are 0x1 for a staged write, 0x2 for a committing write and 0x3 for a read.
- R3: A staged write changes no bit of reg_q before a committing write arrives.
- R4: A committing write applies all staged writes and its own data on the clock edge that samples its data byte. Staged writes apply in arrival order, and the committing write applies last, so the latest write to an address wins. The staging buffer is then empty.
- R5: In the cycle after the data byte of a committing write is sampled, mbus_out is the write acknowledge byte 0x50 (code 0x5 in bits [7:4]). This lasts exactly one cycle.
- R6: In the cycle after the low address byte of a read is sampled, mbus_out is the completion header 0x40 (code 0x4 in bits [7:4]). In the cycle after that, mbus_out is the register value.
- R7: A header byte whose command is 0x0 (idle or NOP) or is 0x4 to 0xF is ignored as a single byte. It does not disturb the staged writes.
- R8: Register bits outside PULSE_MASK (default 0xF0) keep their value until they are written again or reset.
- R9: Register bits inside PULSE_MASK that are written with 1 are high for exactly one cycle, then return to 0 without another write.
- R10: Address bits [11:10] select the region: 0 receive, 1 transmit, 2 common, 3 vendor. Bits [9:0] are the offset. Register region*REGS_PER_REGION+offset appears on reg_q[8*index +: 8]. An offset of REGS_PER_REGION or more is unmapped: a write to it is ignored and a read of it returns 0x00.
- R11: The staging buffer holds STAGE_DEPTH (default 4) writes. A staged write that arrives when the buffer is full is dropped and sets stage_ovf. stage_ovf stays set until reset.
- R12: Outside the beats of R5 and R6, mbus_out is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| mbus_in | input | 8 | Inbound request bytes |
| mbus_out | output | 8 | Outbound response bytes, 0x00 when idle |
| reg_q | output | 8*4*REGS_PER_REGION | Hosted register contents, register 0 in the low byte |
| stage_ovf | output | 1 | Sticky staging-buffer overflow flag |

## Verification
Two situations are hard to reach from the ports. The first is a commit that must merge several staged entries, including two staged writes to the same address, with NOPs and unrecognised header bytes mixed in. The bench stages three writes around an ignored header and idle bytes, checks that reg_q has not moved, and then commits to a third region. It also checks that the pulse bit of the committed value lasts one cycle. The second is overflow. The bench fills all four entries, sends a fifth staged write aimed at a register holding a known older value, commits, and checks that this register kept the older value, that the flag stayed set, and that only reset clears it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 12;

   // command codes carried in header bits [7:4]
   localparam logic [3:0] OP_NOP    = 4'h0;
   localparam logic [3:0] OP_STAGE  = 4'h1;
   localparam logic [3:0] OP_COMMIT = 4'h2;
   localparam logic [3:0] OP_READ   = 4'h3;
   localparam logic [3:0] OP_RDRESP = 4'h4;
   localparam logic [3:0] OP_WRACK  = 4'h5;

   typedef enum logic [1:0] {
      PH_HEAD,
      PH_ADDR,
      PH_DATA
   } phase_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [BYTE_W-1:0] data;
   } wr_ent_t;

endpackage

// File: rtl/mbus_frame_rx.sv
module mbus_frame_rx
   import mbus_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  rx_byte,
   output logic        stage_req,
   output logic        commit_req,
   output logic        read_req,
   output wr_ent_t     req_ent
);

   phase_e     ph_q;
   logic [3:0] op_q;
   logic [3:0] ahi_q;
   logic [7:0] alo_q;
   logic       op_known;

   // only request codes open a frame; NOP and response codes are dropped
   assign op_known = (rx_byte[7:4] == OP_STAGE) || (rx_byte[7:4] == OP_COMMIT) ||
                     (rx_byte[7:4] == OP_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_HEAD;
         op_q  <= OP_NOP;
         ahi_q <= '0;
         alo_q <= '0;
      end else begin
         case (ph_q)
            PH_HEAD: begin
               if (op_known) begin
                  op_q  <= rx_byte[7:4];
                  ahi_q <= rx_byte[3:0];
                  ph_q  <= PH_ADDR;
               end
            end
            PH_ADDR: begin
               alo_q <= rx_byte;
               ph_q  <= (op_q == OP_READ) ? PH_HEAD : PH_DATA;
            end
            default: ph_q <= PH_HEAD;
         endcase
      end
   end

   always_comb begin
      stage_req    = (ph_q == PH_DATA) && (op_q == OP_STAGE);
      commit_req   = (ph_q == PH_DATA) && (op_q == OP_COMMIT);
      read_req     = (ph_q == PH_ADDR) && (op_q == OP_READ);
      req_ent.addr = (ph_q == PH_ADDR) ? {ahi_q, rx_byte} : {ahi_q, alo_q};
      req_ent.data = rx_byte;
   end

   // R2: a read request always returns the parser to header phase
   a_r2_read_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      read_req |=> (ph_q == PH_HEAD));

   // R2: a write data byte always closes the frame
   a_r2_write_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_req || commit_req) |=> (ph_q == PH_HEAD));

endmodule

// File: rtl/mbus_wbuf.sv
module mbus_wbuf
   import mbus_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push,
   input  wr_ent_t               push_ent,
   input  logic                  clear,
   output wr_ent_t [DEPTH-1:0]   ents,
   output logic [DEPTH-1:0]      valid,
   output logic                  overflow
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             full;

   if (DEPTH < 1) begin : g_bad_depth
      $error("mbus_wbuf: DEPTH must be at least 1");
   end

   assign full = (cnt_q == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         overflow <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (push) begin
         if (full) overflow <= 1'b1;
         else      cnt_q    <= cnt_q + 1'b1;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ents[g] <= '0;
         else if (push && !clear && !full && (cnt_q == CNT_W'(g)))
            ents[g] <= push_ent;
      end
      assign valid[g] = (CNT_W'(g) < cnt_q);
   end

   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !clear) |=> ($stable(cnt_q) && $stable(ents)));

   a_r4_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (valid == '0));

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
   import mbus_pkg::*;
#(
   parameter int         RPR        = 2,
   parameter int         DEPTH      = 4,
   parameter logic [7:0] PULSE_MASK = 8'hF0,
   localparam int        NREG       = 4 * RPR
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit,
   input  wr_ent_t               commit_ent,
   input  wr_ent_t [DEPTH-1:0]   buf_ents,
   input  logic [DEPTH-1:0]      buf_valid,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [7:0]            rd_data,
   output logic [NREG*8-1:0]     regs
);

   localparam logic [9:0]        RPR_L     = 10'(RPR);
   localparam logic [NREG*8-1:0] PULSE_ALL = {NREG{PULSE_MASK}};
   localparam logic [NREG*8-1:0] LEVEL_ALL = {NREG{~PULSE_MASK}};

   if (RPR < 1 || RPR > 1023) begin : g_bad_rpr
      $error("mbus_regfile: RPR must lie in 1..1023");
   end

   logic [7:0] q   [NREG];
   logic [7:0] nxt [NREG];

   // region in [11:10], offset in [9:0]; -1 marks an unmapped address
   function automatic int map_idx(input logic [ADDR_W-1:0] a);
      if (a[9:0] >= RPR_L) return -1;
      return int'(a[11:10]) * RPR + int'(a[9:0]);
   endfunction

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         nxt[i] = q[i] & ~PULSE_MASK;
         if (commit) begin
            for (int e = 0; e < DEPTH; e++)
               if (buf_valid[e] && (map_idx(buf_ents[e].addr) == i))
                  nxt[i] = buf_ents[e].data;
            if (map_idx(commit_ent.addr) == i)
               nxt[i] = commit_ent.data;
         end
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[g] <= '0;
         else        q[g] <= nxt[g];
      end
      assign regs[g*8 +: 8] = q[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (map_idx(rd_addr) == i) rd_data = q[i];
   end

   a_r9_pulse_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(regs & PULSE_ALL)) && !commit) |=> !(|(regs & PULSE_ALL)));

   a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs & LEVEL_ALL));

   a_r3_no_change_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !(|(regs & PULSE_ALL))) |=> $stable(regs));

endmodule

// File: rtl/mbus_endpoint.sv
module mbus_endpoint
   import mbus_pkg::*;
#(
   parameter int         REGS_PER_REGION = 2,
   parameter int         STAGE_DEPTH     = 4,
   parameter logic [7:0] PULSE_MASK      = 8'hF0,
   localparam int        NREG            = 4 * REGS_PER_REGION
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        mbus_in,
   output logic [7:0]        mbus_out,
   output logic [NREG*8-1:0] reg_q,
   output logic              stage_ovf
);

   localparam logic [7:0] ACK_BYTE = {OP_WRACK, 4'h0};
   localparam logic [7:0] RDC_BYTE = {OP_RDRESP, 4'h0};

   logic                      stage_req;
   logic                      commit_req;
   logic                      read_req;
   wr_ent_t                   req_ent;
   wr_ent_t [STAGE_DEPTH-1:0] buf_ents;
   logic [STAGE_DEPTH-1:0]    buf_valid;
   logic [7:0]                rd_data;
   logic [7:0]                tx_q;
   logic [7:0]                rd_hold;
   logic                      rd_pend;

   mbus_frame_rx u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_byte    (mbus_in),
      .stage_req  (stage_req),
      .commit_req (commit_req),
      .read_req   (read_req),
      .req_ent    (req_ent)
   );

   mbus_wbuf #(.DEPTH(STAGE_DEPTH)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (stage_req),
      .push_ent (req_ent),
      .clear    (commit_req),
      .ents     (buf_ents),
      .valid    (buf_valid),
      .overflow (stage_ovf)
   );

   mbus_regfile #(
      .RPR        (REGS_PER_REGION),
      .DEPTH      (STAGE_DEPTH),
      .PULSE_MASK (PULSE_MASK)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit_req),
      .commit_ent (req_ent),
      .buf_ents   (buf_ents),
      .buf_valid  (buf_valid),
      .rd_addr    (req_ent.addr),
      .rd_data    (rd_data),
      .regs       (reg_q)
   );

   // response driver: completion header, then the captured data beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rd_hold <= '0;
         rd_pend <= 1'b0;
      end else if (rd_pend) begin
         tx_q    <= rd_hold;
         rd_pend <= 1'b0;
      end else if (read_req) begin
         tx_q    <= RDC_BYTE;
         rd_hold <= rd_data;
         rd_pend <= 1'b1;
      end else if (commit_req) begin
         tx_q <= ACK_BYTE;
      end else begin
         tx_q <= '0;
      end
   end

   assign mbus_out = tx_q;

   a_r5_ack_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> (mbus_out == ACK_BYTE));

   a_r6_rdc_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      read_req |=> (mbus_out == RDC_BYTE));

   a_r12_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_req && !read_req && !rd_pend) |=> (mbus_out == 8'h00));

endmodule

// File: tb/mbus_endpoint_test.sv
module mbus_endpoint_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 10;

   // {address, data written by a committing write, value read back later, register index (15 = unmapped)}
   localparam logic [31:0] VEC [NVEC] = '{
      {12'h000, 8'h5A, 8'h0A, 4'd0},
      {12'h001, 8'h37, 8'h07, 4'd1},
      {12'h400, 8'h0C, 8'h0C, 4'd2},
      {12'h801, 8'hFF, 8'h0F, 4'd5},
      {12'hC00, 8'h03, 8'h03, 4'd6},
      {12'hC01, 8'h09, 8'h09, 4'd7},
      {12'h002, 8'h0F, 8'h00, 4'd15},
      {12'h3FF, 8'h0E, 8'h00, 4'd15},
      {12'h401, 8'hA6, 8'h06, 4'd3},
      {12'h800, 8'h44, 8'h04, 4'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mbus_in = 8'h00;
   logic [7:0]  mbus_out;
   logic [63:0] reg_q;
   logic        stage_ovf;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_endpoint uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mbus_in   (mbus_in),
      .mbus_out  (mbus_out),
      .reg_q     (reg_q),
      .stage_ovf (stage_ovf)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      mbus_in = b;
   endtask

   task automatic idle();
      @(negedge clk);
      mbus_in = 8'h00;
   endtask

   task automatic wr(input logic [3:0] op, input logic [11:0] a, input logic [7:0] d);
      send({op, a[11:8]});
      send(a[7:0]);
      send(d);
   endtask

   task automatic rd_check(input logic [11:0] a, input logic [7:0] exp);
      send({4'h3, a[11:8]});
      send(a[7:0]);
      idle();
      chk("R6 completion header", {56'h0, mbus_out}, 64'h40);
      idle();
      chk("R6 completion data", {56'h0, mbus_out}, {56'h0, exp});
      idle();
      chk("R12 quiet after completion", {56'h0, mbus_out}, 64'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] snap;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 out in reset", {56'h0, mbus_out}, 64'h0);
      chk("R1 regs in reset", reg_q, 64'h0);
      rst_n = 1'b1;
      idle();
      chk("R1 ovf after reset", {63'h0, stage_ovf}, 64'h0);
      chk("R1 regs after reset", reg_q, 64'h0);

      // R3, R7: staging, NOPs and ignored headers leave registers alone
      wr(4'h1, 12'h000, 8'h0B);
      idle();
      chk("R3 staged write invisible", reg_q, 64'h0);
      send(8'h7F);
      send(8'h00);
      wr(4'h1, 12'h400, 8'h0D);
      send(8'h4C);
      wr(4'h1, 12'h000, 8'h01);
      idle();
      idle();
      chk("R3 still invisible", reg_q, 64'h0);
      chk("R12 no response to staging", {56'h0, mbus_out}, 64'h0);

      // R4, R5, R9: commit merges everything on one edge
      wr(4'h2, 12'h801, 8'h82);
      idle();
      chk("R5 write ack", {56'h0, mbus_out}, 64'h50);
      chk("R4 atomic merge in order", reg_q, 64'h00008200000D0001);
      idle();
      chk("R9 pulse bit cleared", reg_q, 64'h00000200000D0001);
      chk("R5 single ack", {56'h0, mbus_out}, 64'h0);
      repeat (3) idle();
      chk("R8 level bits hold", reg_q, 64'h00000200000D0001);

      // table walk: R2, R6, R8, R9, R10
      for (int v = 0; v < NVEC; v++) begin
         logic [11:0] a;
         logic [7:0]  d, e;
         int          ix;
         a  = VEC[v][31:20];
         d  = VEC[v][19:12];
         e  = VEC[v][11:4];
         ix = int'(VEC[v][3:0]);
         snap = reg_q;
         wr(4'h2, a, d);
         idle();
         chk("R5 ack in table", {56'h0, mbus_out}, 64'h50);
         if (ix == 15) begin
            chk("R10 unmapped write ignored", reg_q, snap);
         end else begin
            chk("R10 write lands at index", {56'h0, reg_q[ix*8 +: 8]}, {56'h0, d});
            idle();
            chk("R9 pulse gone, R8 level kept", {56'h0, reg_q[ix*8 +: 8]}, {56'h0, e});
         end
         rd_check(a, e);
      end

      // R11: overflow drops the fifth staged write
      wr(4'h1, 12'h000, 8'h01);
      wr(4'h1, 12'h001, 8'h02);
      wr(4'h1, 12'h400, 8'h03);
      wr(4'h1, 12'h401, 8'h04);
      idle();
      chk("R11 four entries fit", {63'h0, stage_ovf}, 64'h0);
      wr(4'h1, 12'hC00, 8'h08);
      idle();
      chk("R11 overflow raised", {63'h0, stage_ovf}, 64'h1);
      wr(4'h2, 12'hC01, 8'h06);
      idle();
      chk("R5 ack after full buffer", {56'h0, mbus_out}, 64'h50);
      chk("R11 dropped entry not applied", reg_q, 64'h06030F0404030201);
      repeat (4) idle();
      chk("R11 overflow sticky", {63'h0, stage_ovf}, 64'h1);

      // R4: buffer empty after commit, lone commit touches only its target
      wr(4'h2, 12'h800, 8'h07);
      idle();
      chk("R4 buffer emptied by commit", reg_q, 64'h06030F0704030201);

      // R1: reset clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      idle();
      idle();
      rst_n = 1'b1;
      idle();
      chk("R1 ovf cleared by reset", {63'h0, stage_ovf}, 64'h0);
      chk("R1 regs cleared by reset", reg_q, 64'h0);
      chk("R1 out quiet after reset", {56'h0, mbus_out}, 64'h0);

      finish_run();
   end

endmodule